// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block collects up to 256 interrupt lines into one interrupt output. The lines are grouped in blocks of eight, and the blocks are grouped in masters of eight. That gives a three-level summary tree. A root byte shows which masters have pending work. One status byte per master shows which of its blocks have pending lines. Each block has a latched status byte for its eight lines. Software walks down this tree to find the line that needs service.

A synchronous byte-wide register port gives access to the tree. Per-line state is reached through a window. Software first writes a block number to a select register. It then reads that block's latched status or its live input levels, or writes a configuration byte. The configuration byte carries the line index, the level/edge choice, two polarity masks, a clear request and a write-enable bit. Each line can trigger on a rising edge, a falling edge, both edges, a high level or a low level. A line can also be fully masked.

The default build has 80 lines, which gives 10 blocks and 2 masters. The register map has room for four masters. This means the line count must not exceed 256.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset, every line is in edge mode with both masks set, all latched status is zero, the block select is 0, `irq_out` is low and every summary register reads 0.
- R2: In edge mode with the rising mask (config bit 2) clear, a 0-to-1 transition on a line sets its latched status bit. A 1-to-0 transition does not set it when the falling mask (bit 1) is set.
- R3: In edge mode with only the falling mask clear, a 1-to-0 transition sets the latched bit and a 0-to-1 transition does not.
- R4: In edge mode with both masks clear, either transition sets the latched bit.
- R5: In level mode (bit 0 set) with the rising mask clear, a high line sets the latched bit. A clear request issued while the line is still high is followed by the bit setting again. A clear request issued after the line goes low leaves the bit at 0.
- R6: In level mode with the falling mask clear, a low line sets the latched bit. A clear request issued while the line is high leaves it at 0.
- R7: A line with both masks set never latches. A configuration write whose bit 7 is 0 has no effect.
- R8: A configuration write with bit 3 set clears only the line selected by bits 6:4 within the selected block. Writing both masks together with the clear bit (mask-and-acknowledge) clears the line and stops further latching. Rewriting the unmasked setting afterwards makes the line latch again.
- R9: Offset 8 returns the synchronized raw levels of the selected block's eight lines, whatever their masks and latched state.
- R10: Offset 1+m, bit i, is the OR of the latched bits of block m*8+i. Root (offset 0) bit m+1 is the OR of master m's bits, and root bit 0 is always 0. Master registers of masters that do not exist read 0.
- R11: `irq_out` is a register that goes high one clock after any root bit is set, and low one clock after all root bits clear.
- R12: When the block select is at or above the block count, offsets 6 and 8 read 0 and configuration writes change nothing.
- R13: `reg_rdata` loads the addressed register on the clock edge where `reg_rd` is high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | NUM_LINES | Asynchronous interrupt lines |
| reg_addr | input | 4 | Register offset (0 to 8) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions check several properties on every cycle. They check that the combined output follows the root summary with one cycle of delay. They check that any latched line is reflected in the root. They check that read data holds between read strobes, and that an out-of-range block window reads zero. Only the bench scenarios can show the trigger semantics of each mode. That includes one-edge versus both-edge triggering, and the re-latch of an active level after a clear. The bench also covers the per-line reach of the clear and mask-and-acknowledge sequence and the address mapping of blocks onto master bits.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  // configuration byte fields (decoded by the block cells)
  localparam int CB_LVL  = 0;
  localparam int CB_MFE  = 1;
  localparam int CB_MRE  = 2;
  localparam int CB_CLR  = 3;
  localparam int CB_IDX  = 4;
  localparam int CB_WEN  = 7;
  localparam int MAX_MASTERS = 4;

  typedef struct packed {
    logic lvl;
    logic mfe;
    logic mre;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, mfe: 1'b1, mre: 1'b1};

  typedef enum logic [3:0] {
    RA_ROOT = 4'd0,
    RA_MST0 = 4'd1,
    RA_MST1 = 4'd2,
    RA_MST2 = 4'd3,
    RA_MST3 = 4'd4,
    RA_BSEL = 4'd5,
    RA_STAT = 4'd6,
    RA_CFG  = 4'd7,
    RA_LIVE = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl_now,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1   <= '0;
      lvl_now  <= '0;
      lvl_prev <= '0;
    end else begin
      stage1   <= d_in;
      lvl_now  <= stage1;
      lvl_prev <= lvl_now;
    end
  end
endmodule

// File: rtl/irq_block_cell.sv
module irq_block_cell
  import irq_tree_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl_now,
  input  logic [LINES-1:0] lvl_prev,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_byte,
  output logic [LINES-1:0] status
);
  localparam int IDXW = $clog2(LINES);

  logic [IDXW-1:0] idx;
  logic            wen;
  assign idx = cfg_byte[CB_IDX +: IDXW];
  assign wen = cfg_sel && cfg_byte[CB_WEN];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_cfg_t cfg_q;
    logic      hit;
    logic      trig;

    assign hit = wen && (idx == IDXW'(i));

    always_comb begin
      if (cfg_q.lvl)
        trig = (!cfg_q.mre && lvl_now[i]) || (!cfg_q.mfe && !lvl_now[i]);
      else
        trig = (!cfg_q.mre && lvl_now[i] && !lvl_prev[i]) ||
               (!cfg_q.mfe && !lvl_now[i] && lvl_prev[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q     <= CFG_RESET;
        status[i] <= 1'b0;
      end else begin
        if (hit) begin
          cfg_q.lvl <= cfg_byte[CB_LVL];
          cfg_q.mfe <= cfg_byte[CB_MFE];
          cfg_q.mre <= cfg_byte[CB_MRE];
        end
        if (hit && cfg_byte[CB_CLR])
          status[i] <= 1'b0;
        else if (trig)
          status[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_tree_pkg::*;
#(
  parameter int NB = 10,
  parameter int NM = 2
) (
  input  logic [NB*8-1:0]         line_status,
  output logic [MAX_MASTERS*8-1:0] mst_bits,
  output logic [7:0]              root_sum
);
  logic [NB-1:0] blk_any;

  for (genvar b = 0; b < NB; b++) begin : g_blk
    assign blk_any[b] = |line_status[b*8 +: 8];
  end

  for (genvar m = 0; m < MAX_MASTERS; m++) begin : g_mst
    for (genvar i = 0; i < 8; i++) begin : g_bit
      if (m*8 + i < NB) begin : g_on
        assign mst_bits[m*8 + i] = blk_any[m*8 + i];
      end else begin : g_off
        assign mst_bits[m*8 + i] = 1'b0;
      end
    end
    if (m < NM) begin : g_root_on
      assign root_sum[m+1] = |mst_bits[m*8 +: 8];
    end else begin : g_root_off
      assign root_sum[m+1] = 1'b0;
    end
  end

  assign root_sum[0] = 1'b0;
  assign root_sum[7:MAX_MASTERS+1] = '0;
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int NUM_LINES = 80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_in,
  input  logic [3:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  input  logic                 reg_rd,
  output logic [7:0]           reg_rdata,
  output logic                 irq_out
);
  localparam int NB = (NUM_LINES + 7) / 8;
  localparam int NM = (NB + 7) / 8;
  localparam int LP = NB * 8;

  logic [LP-1:0]               line_pad;
  logic [LP-1:0]               lvl_now;
  logic [LP-1:0]               lvl_prev;
  logic [LP-1:0]               stat_flat;
  logic [MAX_MASTERS*8-1:0]    mst_bits;
  logic [7:0]                  root_sum;
  logic [7:0]                  blk_sel_q;
  logic                        cfg_wr;
  logic [7:0]                  rmux;
  logic [7:0]                  sel_stat;
  logic [7:0]                  sel_live;

  assign line_pad = LP'(lines_in);
  assign cfg_wr   = reg_wr && (reg_addr == RA_CFG);

  irq_sync #(.W(LP)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .d_in     (line_pad),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev)
  );

  for (genvar b = 0; b < NB; b++) begin : g_cell
    irq_block_cell #(.LINES(8)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .lvl_now  (lvl_now[b*8 +: 8]),
      .lvl_prev (lvl_prev[b*8 +: 8]),
      .cfg_sel  (cfg_wr && (blk_sel_q == 8'(b))),
      .cfg_byte (reg_wdata),
      .status   (stat_flat[b*8 +: 8])
    );
  end

  irq_summary #(.NB(NB), .NM(NM)) u_sum (
    .line_status (stat_flat),
    .mst_bits    (mst_bits),
    .root_sum    (root_sum)
  );

  always_ff @(posedge clk) begin
    if (rst)
      blk_sel_q <= '0;
    else if (reg_wr && (reg_addr == RA_BSEL))
      blk_sel_q <= reg_wdata;
  end

  always_comb begin
    sel_stat = '0;
    sel_live = '0;
    for (int b = 0; b < NB; b++) begin
      if (blk_sel_q == 8'(b)) begin
        sel_stat = stat_flat[b*8 +: 8];
        sel_live = lvl_now[b*8 +: 8];
      end
    end
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_ROOT: rmux = root_sum;
      RA_MST0: rmux = mst_bits[0 +: 8];
      RA_MST1: rmux = mst_bits[8 +: 8];
      RA_MST2: rmux = mst_bits[16 +: 8];
      RA_MST3: rmux = mst_bits[24 +: 8];
      RA_BSEL: rmux = blk_sel_q;
      RA_STAT: rmux = sel_stat;
      RA_LIVE: rmux = sel_live;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (reg_rd)
        reg_rdata <= rmux;
      irq_out <= |root_sum;
    end
  end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int NB = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_out,
  input logic [7:0]    root_sum,
  input logic [NB*8-1:0] line_status,
  input logic          reg_rd,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input logic [7:0]    blk_sel
);
  // R1: output is low right after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !irq_out)
    else $error("p_reset_quiet_r1");

  // R11: combined output follows the root summary one cycle later
  p_irq_follow_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|root_sum)))
    else $error("p_irq_follow_r11");

  // R10: any latched line appears in the root summary
  p_root_cover_r10: assert property (@(posedge clk) disable iff (rst)
    (|line_status) == (|root_sum))
    else $error("p_root_cover_r10");

  // R13: read data holds without a read strobe
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata))
    else $error("p_rdata_hold_r13");

  // R12: out-of-range window reads zero
  p_window_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && (blk_sel >= 8'(NB)) && (reg_addr == 4'd6 || reg_addr == 4'd8))
      |=> (reg_rdata == 8'h00))
    else $error("p_window_zero_r12");
endmodule

bind irq_tree_ctrl irq_tree_chk #(.NB(NB)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_out     (irq_out),
  .root_sum    (root_sum),
  .line_status (stat_flat),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .blk_sel     (blk_sel_q)
);

// File: tb/sim_irq_tree_ctrl.sv
`timescale 1ns/1ps
module sim_irq_tree_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] lines = '0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_rdata;
  logic          irq_out;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tree_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst(rst), .lines_in(lines), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // cfg byte: bit7 write enable, 6:4 index, 3 clear, 2 rise mask, 1 fall mask, 0 level
  task automatic cfg(input int line, input logic lvl, input logic mfe,
                     input logic mre, input logic clr);
    wr(4'd5, 8'(line / 8));
    wr(4'd7, {1'b1, 3'(line % 8), clr, mre, mfe, lvl});
  endtask

  task automatic blk_stat(input int blk, output logic [7:0] d);
    wr(4'd5, 8'(blk));
    rd(4'd6, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    rd(4'd0, v); chk("R1 root", v, 8'h00);
    rd(4'd1, v); chk("R1 master0", v, 8'h00);
    rd(4'd5, v); chk("R1 block select", v, 8'h00);
    rd(4'd6, v); chk("R1 block0 status", v, 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] v;
    cfg(3, 1'b0, 1'b1, 1'b0, 1'b1);
    lines[3] = 1'b1; settle();
    blk_stat(0, v); chk("R2 rise latched", v, 8'h08);
    chk("R11 irq high", {7'd0, irq_out}, 8'h01);
    rd(4'd0, v); chk("R10 root bit1", v, 8'h02);
    rd(4'd1, v); chk("R10 master0 bit0", v, 8'h01);
    cfg(3, 1'b0, 1'b1, 1'b0, 1'b1); settle();
    chk("R11 irq low after clear", {7'd0, irq_out}, 8'h00);
    lines[3] = 1'b0; settle();
    blk_stat(0, v); chk("R2 fall ignored", v, 8'h00);
  endtask

  task automatic t_falling();
    logic [7:0] v;
    lines[12] = 1'b0;
    cfg(12, 1'b0, 1'b0, 1'b1, 1'b1);
    lines[12] = 1'b1; settle();
    blk_stat(1, v); chk("R3 rise ignored", v, 8'h00);
    lines[12] = 1'b0; settle();
    blk_stat(1, v); chk("R3 fall latched", v, 8'h10);
    rd(4'd1, v); chk("R10 master0 bit1", v, 8'h02);
    cfg(12, 1'b0, 1'b0, 1'b1, 1'b1); settle();
    blk_stat(1, v); chk("R3 cleared", v, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] v;
    cfg(20, 1'b0, 1'b0, 1'b0, 1'b1);
    lines[20] = 1'b1; settle();
    blk_stat(2, v); chk("R4 rise latched", v, 8'h10);
    cfg(20, 1'b0, 1'b0, 1'b0, 1'b1);
    lines[20] = 1'b0; settle();
    blk_stat(2, v); chk("R4 fall latched", v, 8'h10);
    cfg(20, 1'b0, 1'b1, 1'b1, 1'b1); settle();
    blk_stat(2, v); chk("R8 mask-ack clears", v, 8'h00);
  endtask

  task automatic t_level_high();
    logic [7:0] v;
    cfg(9, 1'b1, 1'b1, 1'b0, 1'b1);
    lines[9] = 1'b1; settle();
    blk_stat(1, v); chk("R5 high latched", v, 8'h02);
    cfg(9, 1'b1, 1'b1, 1'b0, 1'b1); settle();
    blk_stat(1, v); chk("R5 relatch while high", v, 8'h02);
    lines[9] = 1'b0; settle();
    cfg(9, 1'b1, 1'b1, 1'b0, 1'b1); settle();
    blk_stat(1, v); chk("R5 clear after low", v, 8'h00);
  endtask

  task automatic t_level_low();
    logic [7:0] v;
    lines[30] = 1'b1; settle();
    cfg(30, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    blk_stat(3, v); chk("R6 high not active", v, 8'h00);
    lines[30] = 1'b0; settle();
    blk_stat(3, v); chk("R6 low latched", v, 8'h40);
    lines[30] = 1'b1; settle();
    cfg(30, 1'b1, 1'b0, 1'b1, 1'b1); settle();
    blk_stat(3, v); chk("R6 cleared while high", v, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    lines[5] = 1'b1; settle(); lines[5] = 1'b0; settle();
    blk_stat(0, v); chk("R7 masked no latch", v, 8'h00);
    wr(4'd5, 8'd0);
    wr(4'd7, 8'b0_101_0_0_0_0);   // no write enable: stays masked
    lines[5] = 1'b1; settle(); lines[5] = 1'b0; settle();
    blk_stat(0, v); chk("R7 write without enable ignored", v, 8'h00);
  endtask

  task automatic t_mask_ack();
    logic [7:0] v;
    cfg(6, 1'b0, 1'b1, 1'b0, 1'b1);
    cfg(7, 1'b0, 1'b1, 1'b0, 1'b1);
    lines[6] = 1'b1; lines[7] = 1'b1; settle();
    blk_stat(0, v); chk("R8 both latched", v, 8'hC0);
    cfg(6, 1'b0, 1'b1, 1'b1, 1'b1); settle();
    blk_stat(0, v); chk("R8 clear only line6", v, 8'h80);
    lines[6] = 1'b0; settle(); lines[6] = 1'b1; settle();
    blk_stat(0, v); chk("R8 masked stays clear", v, 8'h80);
    cfg(6, 1'b0, 1'b1, 1'b0, 1'b0);
    lines[6] = 1'b0; settle(); lines[6] = 1'b1; settle();
    blk_stat(0, v); chk("R8 unmask relatches", v, 8'hC0);
    cfg(6, 1'b0, 1'b1, 1'b1, 1'b1);
    cfg(7, 1'b0, 1'b1, 1'b1, 1'b1);
    lines[6] = 1'b0; lines[7] = 1'b0; settle();
    blk_stat(0, v); chk("R8 cleanup", v, 8'h00);
  endtask

  task automatic t_master2();
    logic [7:0] v;
    cfg(70, 1'b0, 1'b1, 1'b0, 1'b1);
    lines[70] = 1'b1; settle();
    blk_stat(8, v); chk("R10 block8 status", v, 8'h40);
    rd(4'd2, v); chk("R10 master1 bit0", v, 8'h01);
    rd(4'd1, v); chk("R10 master0 idle", v, 8'h00);
    rd(4'd0, v); chk("R10 root bit2", v, 8'h04);
    rd(4'd4, v); chk("R10 absent master", v, 8'h00);
    chk("R11 irq from master1", {7'd0, irq_out}, 8'h01);
    cfg(70, 1'b0, 1'b1, 1'b1, 1'b1);
    lines[70] = 1'b0; settle();
    rd(4'd0, v); chk("R10 root clear", v, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] v;
    lines[23:16] = 8'hA5; settle();
    wr(4'd5, 8'd2);
    rd(4'd8, v); chk("R9 live level", v, 8'hA5);
    rd(4'd6, v); chk("R9 masked lines not latched", v, 8'h00);
    lines[23:16] = 8'h00; settle();
    rd(4'd8, v); chk("R9 live level low", v, 8'h00);
  endtask

  task automatic t_range();
    logic [7:0] v;
    lines[79:72] = 8'hFF; settle();
    wr(4'd5, 8'd10);
    rd(4'd6, v); chk("R12 status out of range", v, 8'h00);
    rd(4'd8, v); chk("R12 live out of range", v, 8'h00);
    wr(4'd7, 8'b1_000_0_0_0_0);
    rd(4'd0, v); chk("R12 write ignored", v, 8'h00);
    lines[79:72] = 8'h00; settle();
  endtask

  task automatic t_rdhold();
    logic [7:0] v;
    cfg(3, 1'b0, 1'b1, 1'b0, 1'b1);
    lines[3] = 1'b1; settle();
    rd(4'd0, v); chk("R13 read root", v, 8'h02);
    cfg(3, 1'b0, 1'b1, 1'b1, 1'b1); settle();
    chk("R13 rdata held", reg_rdata, 8'h02);
    chk("R11 irq dropped", {7'd0, irq_out}, 8'h00);
    lines[3] = 1'b0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_level_high();
    t_level_low();
    t_masked();
    t_mask_ack();
    t_master2();
    t_live();
    t_range();
    t_rdhold();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule